// File: doc/BRIEF.md
# Mailbox Indirect Register Access Engine

This engine lets a host that cannot address a register file directly reach it through a mailbox. The host sees a small bank of word registers: a target address, a data word, two context words (a control word and an index word), a status word and a command word. It loads the address, data and both context words, presets the status to busy, and then writes the command. Writing the command starts the access. Writing the data does not.

On a valid command the engine performs one read or write on an internal register bus. That bus uses a valid/ready handshake and carries a response error bit. The two context words travel with the request. The target address is a word index, so the engine sends the byte address (the index times four). When the access ends, the engine writes a completion or error code into the status word, and a read result into the data word. It never puts itself back into busy. The host polls status until it leaves busy.

The engine checks the command value and the target address before it touches the bus. A bad command or an address outside the allowed range ends at once with its own status code, and nothing appears on the bus. An error response, or no ready within a set number of cycles, ends the access with a catch-all error code.

Top module: `mbx_reg_bridge`

## Requirements
- R1: After reset the status word reads 0x01, the command, address, data and both context words read 0, and no bus request is active.
- R2: The host word offsets are: command 0x99A, status 0x99B, context index 0x99C, context control 0x99D, target address 0x99E, data 0x99F. Address, data, both context words and status read back what the host last wrote while the engine is idle. Status reads with bits 31:8 zero.
- R3: Writing command 0x0 while idle issues exactly one bus write. The request carries byte address = target address × 4, the data word, the context control word and the context index word. Ready without error sets status to 0x01 and leaves the data word unchanged.
- R4: Writing command 0x1 while idle issues exactly one bus read with the same address and context fields. On ready without error, the returned value is placed in the data word in the same clock edge that sets status to 0x01.
- R5: Writing any other 32-bit command value while idle sets status to 0x02 in the clock edge of the command write, and no bus request is issued.
- R6: A valid command whose target address lies outside [ADDR_LO, ADDR_HI] (all 32 bits compared) sets status to 0x03 in the command-write edge, and no bus request is issued.
- R7: A ready carrying the error bit ends the access with status 0xFF. On a read the data word is left unchanged.
- R8: A request that sees no ready for TIMEOUT_CYC consecutive cycles is withdrawn, and status becomes 0xFF.
- R9: While an access is in progress, host writes to the command, address, data, context and status words are ignored. Exactly one bus request results.
- R10: Status changes to busy (0x00) only through a host write of 0x00 to the status word.
- R11: While a request waits for ready, its address, data, write flag and context fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_wr_i | input | 1 | Host write strobe |
| host_wofs_i | input | 12 | Host write word offset |
| host_wdata_i | input | 32 | Host write data |
| host_rofs_i | input | 12 | Host read word offset |
| host_rdata_o | output | 32 | Host read data, combinational from host_rofs_i |
| bus_valid_o | output | 1 | Internal bus request valid |
| bus_ready_i | input | 1 | Internal bus ready; response fields are valid with it |
| bus_write_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | TAW+2 | Byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ctx_ctl_o | output | 32 | Context control word for this access |
| bus_ctx_idx_o | output | 32 | Context index word for this access |
| bus_rdata_i | input | 32 | Read data returned with ready |
| bus_err_i | input | 1 | Error response returned with ready |

## Verification
Directed accesses cover each outcome separately: a clean write, a clean read, an invalid command (0x2 and all ones), the four address boundary values plus an address with its upper bits set, an error response and a response one cycle past the timeout. A response exactly one cycle inside the timeout must still succeed, which separates an off-by-one timeout from a correct one. A long-latency read with overlapping host writes shows whether locking holds the request fields, and whether a second command is dropped. Random accesses then mix commands, addresses, latencies and error responses, so that the status code, the data word and the request count are checked against independently computed outcomes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW     = 32;
  localparam int HOFS_W = 12;

  localparam logic [HOFS_W-1:0] OFS_CMD  = 12'h99A;
  localparam logic [HOFS_W-1:0] OFS_STAT = 12'h99B;
  localparam logic [HOFS_W-1:0] OFS_IDX  = 12'h99C;
  localparam logic [HOFS_W-1:0] OFS_CTL  = 12'h99D;
  localparam logic [HOFS_W-1:0] OFS_ADDR = 12'h99E;
  localparam logic [HOFS_W-1:0] OFS_DATA = 12'h99F;

  localparam logic [DW-1:0] CMD_WR = 32'h0;
  localparam logic [DW-1:0] CMD_RD = 32'h1;

  typedef enum logic [7:0] {
    ST_BUSY     = 8'h00,
    ST_DONE     = 8'h01,
    ST_BAD_CMD  = 8'h02,
    ST_BAD_ADDR = 8'h03,
    ST_FAULT    = 8'hFF
  } mbx_stat_e;
endpackage

// File: rtl/mbx_host_bank.sv
module mbx_host_bank
  import mbx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [HOFS_W-1:0] wofs_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [HOFS_W-1:0] rofs_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              lock_i,
  input  logic              fin_i,
  input  logic [7:0]        fin_stat_i,
  input  logic              fin_load_i,
  input  logic [DW-1:0]     fin_data_i,
  output logic              cmd_fire_o,
  output logic [DW-1:0]     addr_o,
  output logic [DW-1:0]     data_o,
  output logic [DW-1:0]     ctl_o,
  output logic [DW-1:0]     idx_o,
  output logic [7:0]        stat_o
);
  logic [DW-1:0] cmd_q, addr_q, data_q, ctl_q, idx_q;
  logic [7:0]    stat_q;
  logic          wr_ok;

  assign wr_ok      = wr_i && !lock_i;
  assign cmd_fire_o = wr_ok && (wofs_i == OFS_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      ctl_q  <= '0;
      idx_q  <= '0;
      stat_q <= ST_DONE;
    end else begin
      if (wr_ok) begin
        unique case (wofs_i)
          OFS_CMD:  cmd_q  <= wdata_i;
          OFS_ADDR: addr_q <= wdata_i;
          OFS_CTL:  ctl_q  <= wdata_i;
          OFS_IDX:  idx_q  <= wdata_i;
          default: ;
        endcase
      end
      // engine completion wins over host writes
      if (fin_i) stat_q <= fin_stat_i;
      else if (wr_ok && wofs_i == OFS_STAT) stat_q <= wdata_i[7:0];
      if (fin_load_i) data_q <= fin_data_i;
      else if (wr_ok && wofs_i == OFS_DATA) data_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (rofs_i)
      OFS_CMD:  rdata_o = cmd_q;
      OFS_STAT: rdata_o = {{(DW-8){1'b0}}, stat_q};
      OFS_IDX:  rdata_o = idx_q;
      OFS_CTL:  rdata_o = ctl_q;
      OFS_ADDR: rdata_o = addr_q;
      OFS_DATA: rdata_o = data_q;
      default:  rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign ctl_o  = ctl_q;
  assign idx_o  = idx_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter logic [DW-1:0] ADDR_LO = 32'h0000_0100,
  parameter logic [DW-1:0] ADDR_HI = 32'h0000_EFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_fire_i,
  input  logic [DW-1:0] cmd_i,
  input  logic [DW-1:0] addr_i,
  input  logic          bus_fin_i,
  input  logic          bus_err_i,
  output logic          active_o,
  output logic          start_o,
  output logic          write_o,
  output logic          fin_o,
  output logic [7:0]    fin_stat_o,
  output logic          fin_load_o
);
  logic active_q, write_q, cmd_ok, addr_ok, launch;

  assign cmd_ok  = (cmd_i == CMD_WR) || (cmd_i == CMD_RD);
  assign addr_ok = (addr_i >= ADDR_LO) && (addr_i <= ADDR_HI);
  assign launch  = !active_q && cmd_fire_i;
  assign start_o = launch && cmd_ok && addr_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      write_q  <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      write_q  <= (cmd_i == CMD_WR);
    end else if (active_q && bus_fin_i) begin
      active_q <= 1'b0;
    end
  end

  always_comb begin
    fin_o      = 1'b0;
    fin_stat_o = ST_DONE;
    fin_load_o = 1'b0;
    if (launch && !cmd_ok) begin
      fin_o      = 1'b1;
      fin_stat_o = ST_BAD_CMD;
    end else if (launch && !addr_ok) begin
      fin_o      = 1'b1;
      fin_stat_o = ST_BAD_ADDR;
    end else if (active_q && bus_fin_i) begin
      fin_o      = 1'b1;
      fin_stat_o = bus_err_i ? ST_FAULT : ST_DONE;
      fin_load_o = !write_q && !bus_err_i;
    end
  end

  assign active_o = active_q;
  assign write_o  = write_q;
endmodule

// File: rtl/mbx_bus_master.sv
module mbx_bus_master
  import mbx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64,
  localparam int CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  input  logic rsp_err_i,
  output logic valid_o,
  output logic fin_o,
  output logic err_o
);
  logic          valid_q, tmo_hit;
  logic [CW-1:0] wait_q;

  assign tmo_hit = valid_q && !ready_i && (wait_q == CW'(TIMEOUT_CYC - 1));
  assign fin_o   = valid_q && (ready_i || tmo_hit);
  assign err_o   = !ready_i || rsp_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wait_q  <= '0;
    end else if (start_i) begin
      valid_q <= 1'b1;
      wait_q  <= '0;
    end else if (fin_o) begin
      valid_q <= 1'b0;
      wait_q  <= '0;
    end else if (valid_q) begin
      wait_q  <= wait_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/mbx_reg_bridge.sv
module mbx_reg_bridge
  import mbx_pkg::*;
#(
  parameter int            TAW         = 16,
  parameter logic [31:0]   ADDR_LO     = 32'h0000_0100,
  parameter logic [31:0]   ADDR_HI     = 32'h0000_EFFF,
  parameter int            TIMEOUT_CYC = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_wr_i,
  input  logic [11:0]       host_wofs_i,
  input  logic [31:0]       host_wdata_i,
  input  logic [11:0]       host_rofs_i,
  output logic [31:0]       host_rdata_o,
  output logic              bus_valid_o,
  input  logic              bus_ready_i,
  output logic              bus_write_o,
  output logic [TAW+1:0]    bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  output logic [31:0]       bus_ctx_ctl_o,
  output logic [31:0]       bus_ctx_idx_o,
  input  logic [31:0]       bus_rdata_i,
  input  logic              bus_err_i
);
  logic          cmd_fire, active, start, fin, fin_load, bus_fin, bus_err;
  logic [7:0]    fin_stat, stat_code;
  logic [DW-1:0] addr_reg, data_reg, ctl_reg, idx_reg;

  mbx_host_bank u_bank (
    .clk_i, .rst_ni,
    .wr_i       (host_wr_i),
    .wofs_i     (host_wofs_i),
    .wdata_i    (host_wdata_i),
    .rofs_i     (host_rofs_i),
    .rdata_o    (host_rdata_o),
    .lock_i     (active),
    .fin_i      (fin),
    .fin_stat_i (fin_stat),
    .fin_load_i (fin_load),
    .fin_data_i (bus_rdata_i),
    .cmd_fire_o (cmd_fire),
    .addr_o     (addr_reg),
    .data_o     (data_reg),
    .ctl_o      (ctl_reg),
    .idx_o      (idx_reg),
    .stat_o     (stat_code)
  );

  mbx_seq #(.ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI)) u_seq (
    .clk_i, .rst_ni,
    .cmd_fire_i (cmd_fire),
    .cmd_i      (host_wdata_i),
    .addr_i     (addr_reg),
    .bus_fin_i  (bus_fin),
    .bus_err_i  (bus_err),
    .active_o   (active),
    .start_o    (start),
    .write_o    (bus_write_o),
    .fin_o      (fin),
    .fin_stat_o (fin_stat),
    .fin_load_o (fin_load)
  );

  mbx_bus_master #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_bus (
    .clk_i, .rst_ni,
    .start_i   (start),
    .ready_i   (bus_ready_i),
    .rsp_err_i (bus_err_i),
    .valid_o   (bus_valid_o),
    .fin_o     (bus_fin),
    .err_o     (bus_err)
  );

  // word index to byte address
  assign bus_addr_o    = {addr_reg[TAW-1:0], 2'b00};
  assign bus_wdata_o   = data_reg;
  assign bus_ctx_ctl_o = ctl_reg;
  assign bus_ctx_idx_o = idx_reg;
endmodule

// File: rtl/mbx_reg_bridge_chk.sv
module mbx_reg_bridge_chk
  import mbx_pkg::*;
#(
  parameter int TAW         = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           host_wr_i,
  input logic [11:0]    host_wofs_i,
  input logic [31:0]    host_wdata_i,
  input logic           bus_valid_o,
  input logic           bus_ready_i,
  input logic           bus_write_o,
  input logic [TAW+1:0] bus_addr_o,
  input logic [31:0]    bus_wdata_o,
  input logic [31:0]    bus_ctx_ctl_o,
  input logic [31:0]    bus_ctx_idx_o,
  input logic [31:0]    bus_rdata_i,
  input logic           bus_err_i,
  input logic [7:0]     stat_code,
  input logic [31:0]    data_reg
);
  int unsigned wcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wcnt <= 0;
    else if (bus_valid_o && !bus_ready_i) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  AST_NO_SELF_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_code != ST_BUSY) &&
    !(host_wr_i && host_wofs_i == OFS_STAT && host_wdata_i[7:0] == 8'h00)
    |=> stat_code != ST_BUSY); // R10

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> !bus_valid_o ||
    ($stable(bus_addr_o) && $stable(bus_wdata_o) && $stable(bus_write_o) &&
     $stable(bus_ctx_ctl_o) && $stable(bus_ctx_idx_o))); // R11

  AST_WAIT_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o |-> wcnt < TIMEOUT_CYC); // R8

  AST_BAD_CMD_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wr_i && host_wofs_i == OFS_CMD && !bus_valid_o && host_wdata_i > 32'h1
    |=> !bus_valid_o && stat_code == ST_BAD_CMD); // R5

  AST_HANDSHAKE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i |=> !bus_valid_o && stat_code != ST_BUSY); // R3

  AST_READ_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i && !bus_write_o && !bus_err_i
    |=> data_reg == $past(bus_rdata_i) && stat_code == ST_DONE); // R4

  AST_ERR_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i && bus_err_i |=> stat_code == ST_FAULT); // R7
endmodule

bind mbx_reg_bridge mbx_reg_bridge_chk #(.TAW(TAW), .TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i, .rst_ni, .host_wr_i, .host_wofs_i, .host_wdata_i,
  .bus_valid_o, .bus_ready_i, .bus_write_o, .bus_addr_o, .bus_wdata_o,
  .bus_ctx_ctl_o, .bus_ctx_idx_o, .bus_rdata_i, .bus_err_i,
  .stat_code, .data_reg
);

// File: tb/mbx_reg_bridge_bench.sv
`timescale 1ns/1ps
module mbx_reg_bridge_bench;
  localparam int          TAW = 16;
  localparam logic [31:0] LO  = 32'h0000_0100;
  localparam logic [31:0] HI  = 32'h0000_EFFF;
  localparam int          TMO = 64;
  localparam logic [11:0] O_CMD = 12'h99A, O_STAT = 12'h99B, O_IDX = 12'h99C,
                          O_CTL = 12'h99D, O_ADDR = 12'h99E, O_DATA = 12'h99F;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0;
  logic [11:0] host_wofs = 0, host_rofs = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic bus_valid, bus_ready = 0, bus_write, bus_err = 0;
  logic [TAW+1:0] bus_addr;
  logic [31:0] bus_wdata, bus_ctl, bus_idx, bus_rdata = 0;

  int checks = 0, fails = 0;
  int rsp_lat = 0;
  logic rsp_err = 0;
  int wcnt = 0, req_cnt = 0;
  logic [TAW+1:0] cap_addr;
  logic [31:0] cap_wdata, cap_ctl, cap_idx;
  logic cap_write;

  always #4 clk = ~clk;

  mbx_reg_bridge #(.TAW(TAW), .ADDR_LO(LO), .ADDR_HI(HI), .TIMEOUT_CYC(TMO)) u_mbx_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .host_wr_i(host_wr), .host_wofs_i(host_wofs), .host_wdata_i(host_wdata),
    .host_rofs_i(host_rofs), .host_rdata_o(host_rdata),
    .bus_valid_o(bus_valid), .bus_ready_i(bus_ready), .bus_write_o(bus_write),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_ctx_ctl_o(bus_ctl),
    .bus_ctx_idx_o(bus_idx), .bus_rdata_i(bus_rdata), .bus_err_i(bus_err));

  function automatic logic [31:0] mem_model(logic [31:0] ba, logic [31:0] c, logic [31:0] x);
    return ba ^ (c * 32'h9E37_79B9) ^ {x[15:0], x[31:16]};
  endfunction

  function automatic logic [7:0] exp_stat(logic [31:0] cmd, logic [31:0] a, int lat, logic e);
    if (cmd > 32'h1) return 8'h02;
    if (a < LO || a > HI) return 8'h03;
    if (lat >= TMO) return 8'hFF;
    if (e) return 8'hFF;
    return 8'h01;
  endfunction

  // bus responder: ready after rsp_lat waiting cycles
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ready <= 0; wcnt <= 0;
    end else if (bus_ready) begin
      bus_ready <= 0; wcnt <= 0;
    end else if (bus_valid) begin
      if (wcnt == 0) req_cnt <= req_cnt + 1;
      cap_addr <= bus_addr; cap_wdata <= bus_wdata; cap_write <= bus_write;
      cap_ctl <= bus_ctl; cap_idx <= bus_idx;
      if (wcnt == rsp_lat) begin
        bus_ready <= 1;
        bus_err   <= rsp_err;
        bus_rdata <= mem_model({14'b0, bus_addr}, bus_ctl, bus_idx);
      end else wcnt <= wcnt + 1;
    end else wcnt <= 0;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [11:0] o, logic [31:0] v);
    @(negedge clk);
    host_wr = 1; host_wofs = o; host_wdata = v;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hrd(logic [11:0] o, output logic [31:0] v);
    host_rofs = o;
    #1 v = host_rdata;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic access(logic [31:0] cmd, logic [31:0] a, logic [31:0] d,
                        logic [31:0] c, logic [31:0] x, int lat, logic e);
    logic [31:0] st, dr;
    logic [7:0] es;
    int r0;
    string tag;
    rsp_lat = lat; rsp_err = e;
    hwr(O_ADDR, a); hwr(O_DATA, d); hwr(O_CTL, c); hwr(O_IDX, x);
    hwr(O_STAT, 32'h0);
    r0 = req_cnt;
    hwr(O_CMD, cmd);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      hrd(O_STAT, st);
      if (st != 0) break;
    end
    es = exp_stat(cmd, a, lat, e);
    case (es)
      8'h02: tag = "R5";
      8'h03: tag = "R6";
      8'hFF: tag = (lat >= TMO) ? "R8" : "R7";
      default: tag = (cmd == 0) ? "R3" : "R4";
    endcase
    check({tag, " status"}, st, {24'b0, es});
    check({tag, " request count"}, req_cnt - r0, (es == 8'h02 || es == 8'h03) ? 0 : 1);
    hrd(O_DATA, dr);
    check({tag, " data word"}, dr,
          (es == 8'h01 && cmd == 1) ? mem_model(a << 2, c, x) : d);
    if (es != 8'h02 && es != 8'h03) begin
      check({tag, " byte address"}, {14'b0, cap_addr}, a << 2);
      check({tag, " context"}, cap_ctl ^ {cap_idx[15:0], cap_idx[31:16]},
            c ^ {x[15:0], x[31:16]});
      check({tag, " write flag"}, {31'b0, cap_write}, {31'b0, cmd == 0});
      if (cmd == 0) check({tag, " write data"}, cap_wdata, d);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset values
    hrd(O_STAT, v); check("R1 status", v, 32'h1);
    hrd(O_CMD, v);  check("R1 cmd", v, 0);
    hrd(O_ADDR, v); check("R1 addr", v, 0);
    hrd(O_DATA, v); check("R1 data", v, 0);
    hrd(O_CTL, v);  check("R1 ctl", v, 0);
    hrd(O_IDX, v);  check("R1 idx", v, 0);
    check("R1 valid", {31'b0, bus_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R2 readback
    hwr(O_ADDR, 32'h1234_5678); hrd(O_ADDR, v); check("R2 addr", v, 32'h1234_5678);
    hwr(O_DATA, 32'hCAFE_0001); hrd(O_DATA, v); check("R2 data", v, 32'hCAFE_0001);
    hwr(O_CTL, 32'h0000_00A5);  hrd(O_CTL, v);  check("R2 ctl", v, 32'hA5);
    hwr(O_IDX, 32'h8000_0003);  hrd(O_IDX, v);  check("R2 idx", v, 32'h8000_0003);
    hwr(O_STAT, 32'hFFFF_FF03); hrd(O_STAT, v); check("R2 status", v, 32'h3);
    // directed
    access(0, 32'h200, 32'hDEAD_BEEF, 32'h11, 32'h22, 2, 0);   // R3
    access(1, 32'h300, 32'h5555_AAAA, 32'h7, 32'h9, 0, 0);     // R4
    access(2, 32'h300, 32'h1, 0, 0, 0, 0);                     // R5
    access(32'hFFFF_FFFF, 32'h300, 32'h1, 0, 0, 0, 0);         // R5
    access(1, LO, 32'h2, 1, 2, 1, 0);                          // R6 edge in
    access(0, HI, 32'h3, 3, 4, 1, 0);                          // R6 edge in
    access(1, LO - 1, 32'h4, 0, 0, 0, 0);                      // R6
    access(0, HI + 1, 32'h5, 0, 0, 0, 0);                      // R6
    access(1, 32'h0001_0200, 32'h6, 0, 0, 0, 0);               // R6 upper bits
    access(1, 32'h400, 32'h7777_0000, 5, 6, 3, 1);             // R7
    access(1, 32'h500, 32'h8, 5, 6, TMO, 0);                   // R8
    access(1, 32'h500, 32'h9, 5, 6, TMO - 1, 0);               // R8 just inside
    // R9 overlap
    rsp_lat = 30; rsp_err = 0;
    begin
      int r0;
      hwr(O_ADDR, 32'h600); hwr(O_DATA, 32'h1111); hwr(O_CTL, 32'h2); hwr(O_IDX, 32'h3);
      hwr(O_STAT, 0);
      r0 = req_cnt;
      hwr(O_CMD, 1);
      hwr(O_CMD, 0);
      hwr(O_ADDR, 32'h700);
      hwr(O_DATA, 32'h2222);
      hwr(O_CTL, 32'h9);
      hwr(O_STAT, 32'h2);
      hrd(O_ADDR, v); check("R9 addr locked", v, 32'h600);
      hrd(O_DATA, v); check("R9 data locked", v, 32'h1111);
      hrd(O_CTL, v);  check("R9 ctl locked", v, 32'h2);
      hrd(O_STAT, v); check("R9 status locked", v, 0);
      repeat (40) @(negedge clk);
      hrd(O_STAT, v); check("R9 status", v, 1);
      hrd(O_DATA, v); check("R9 read data", v, mem_model(32'h600 << 2, 2, 3));
      check("R9 single request", req_cnt - r0, 1);
      check("R9 byte address", {14'b0, cap_addr}, 32'h600 << 2);
    end
    // R10 status stays after completion
    repeat (5) @(negedge clk);
    hrd(O_STAT, v); check("R10 no self busy", v, 1);
    // random
    for (int n = 0; n < 40; n++) begin
      int sel, lat;
      logic [31:0] cmd, a;
      logic e;
      sel = $urandom % 8;
      a   = LO + ($urandom % (HI - LO + 1));
      cmd = (sel < 3) ? 0 : 1;
      if (sel == 6) cmd = $urandom | 32'h2;
      if (sel == 7) a = HI + 1 + ($urandom % 1000);
      lat = ($urandom % 15 == 0) ? TMO : int'($urandom % 12);
      e   = ($urandom % 10 == 0);
      access(cmd, a, $urandom, $urandom, $urandom, lat, e);
    end
    finish_run();
  end
endmodule